// File: doc/BRIEF.md
# Bus Tenure Timeout and Error Monitor

This block sits beside the arbitration logic of a pipelined system bus and watches it for protocol faults. It sees a strobe when an address tenure opens and when it closes, the same pair of strobes for data tenures, the transaction type code and master number that come with each address start, and a transfer-error pulse. It does not arbitrate and does not decode addresses. It only observes the bus and reports what it sees.

Each tenure kind has its own watchdog. The watchdog threshold is a programmable 16-bit cycle count, and a threshold of zero turns that watchdog off. The monitor sorts the type code of each address start into one of four kinds: data transfer, address-only, reserved or illegal. The last three kinds are error events, as are a timeout and a bus transfer error. Six event kinds exist in total. Each one sets its own sticky status bit, which software clears by writing one to that bit. The type and master of the first error since the status was last empty are captured for software.

Every event kind has an enable bit and a routing bit. The routing bit sends the event to a regular interrupt line or to a machine-check line. Each line is the OR of the status bits that are enabled and routed to it.

Top module: `bus_err_mon`

## Requirements
- R1: After reset, the status is all zero, both interrupt lines are low, and the captured type and master are zero.
- R2: Let the address threshold be L, with L > 0. If no end strobe arrives in the L cycles that follow the address start cycle, the address timeout status bit 0 sets at the end of the L-th cycle. An end strobe in any of those cycles, including the L-th, prevents the timeout.
- R3: The data watchdog applies the same rule to data tenures, using data threshold D and setting status bit 1.
- R4: A threshold of zero disables its watchdog, so that watchdog never raises its timeout event.
- R5: A new start strobe during an open tenure restarts that watchdog from zero. Address strobes have no effect on the data watchdog.
- R6: The type code is 5 bits and is read only in the address start cycle. Codes 0x00 to 0x0F are data transfers and raise no event. Codes 0x10 to 0x17 are address-only and set bit 2. Codes 0x18 to 0x1B are reserved and set bit 3. Codes 0x1C to 0x1F are illegal and set bit 4. A code present without an address start is ignored.
- R7: A transfer-error pulse sets status bit 5 at the next clock edge.
- R8: Status bits are sticky. A clear write removes exactly the bits written as one, and an event in the same cycle as its clear write leaves the bit set.
- R9: The first event after an empty status captures the type code and the master. For a type event these are the live values. For other events they are the values latched at the most recent address start. The capture holds while any status bit stays set.
- R10: The regular line is the OR of the status bits with enable=1 and route=0. The machine-check line is the OR of the status bits with enable=1 and route=1.
- R11: A disabled event still sets its status bit but raises neither line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_start | input | 1 | Address tenure begins this cycle |
| addr_end | input | 1 | Address tenure ends this cycle |
| data_start | input | 1 | Data tenure begins this cycle |
| data_end | input | 1 | Data tenure ends this cycle |
| ttype | input | 5 | Transaction type code, read with addr_start |
| mid | input | MID_W | Master number, read with addr_start |
| xfer_err | input | 1 | Transfer error pulse |
| addr_limit | input | CNT_W | Address watchdog threshold, 0 = off |
| data_limit | input | CNT_W | Data watchdog threshold, 0 = off |
| irq_en | input | 6 | Per-event interrupt enable |
| mc_sel | input | 6 | Per-event route: 1 = machine check, 0 = regular |
| clr_wr | input | 1 | Clear write strobe |
| clr_bits | input | 6 | Write-one-to-clear bit pattern |
| status | output | 6 | Sticky event status |
| cap_type | output | 5 | Type code of the first error |
| cap_mid | output | MID_W | Master of the first error |
| irq | output | 1 | Regular interrupt line |
| mchk | output | 1 | Machine-check line |

## Verification
The assertions check the following on every cycle:
- A zero threshold never yields a timeout.
- Status bits never drop without a clear write.
- A transfer error or an illegal type code always leaves its bit set on the next cycle.
- Both lines stay low while no enabled bit is set.
- The capture stays still while status is held.

The exact timeout cycle, including the boundary where the end strobe arrives in the last allowed cycle, can only be shown by the bench's scenarios. The same holds for a restart in mid-tenure, the type-code ranges, set-over-clear, and the way routing and enable combine.

// File: rtl/bem_pkg.sv
package bem_pkg;
  localparam int NEV    = 6;
  localparam int TYPE_W = 5;

  localparam int EV_ATO   = 0;
  localparam int EV_DTO   = 1;
  localparam int EV_AONLY = 2;
  localparam int EV_RSVD  = 3;
  localparam int EV_ILL   = 4;
  localparam int EV_TEA   = 5;

  typedef enum logic [1:0] {TK_DATA, TK_AONLY, TK_RSVD, TK_ILL} tkind_e;

  // Decode the kind of a transaction from its top three type bits.
  function automatic tkind_e type_kind(input logic [2:0] top);
    if (!top[2])      return TK_DATA;
    else if (!top[1]) return TK_AONLY;
    else if (!top[0]) return TK_RSVD;
    else              return TK_ILL;
  endfunction

  // OR of the status bits that are enabled and routed to the chosen line.
  function automatic logic line_or(input logic [NEV-1:0] st,
                                   input logic [NEV-1:0] en,
                                   input logic [NEV-1:0] sel,
                                   input logic           want_mc);
    logic [NEV-1:0] route;
    route = want_mc ? sel : ~sel;
    return |(st & en & route);
  endfunction

  // Expiry test: the cycle count has reached the last allowed cycle.
  function automatic logic at_limit(input logic [15:0] cnt,
                                    input logic [15:0] lim);
    return (lim != 16'd0) && (cnt >= lim - 16'd1);
  endfunction
endpackage

// File: rtl/bem_timer.sv
module bem_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  import bem_pkg::*;

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      cnt16;
  logic [15:0]      lim16;

  assign cnt16  = 16'(cnt);
  assign lim16  = 16'(limit);
  assign expire = active && !start && !stop && at_limit(cnt16, lim16);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (stop || expire) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bem_classify.sv
module bem_classify (
  input  logic       valid,
  input  logic [2:0] ttop,
  output logic [2:0] hit
);
  import bem_pkg::*;

  tkind_e kind;
  assign kind = type_kind(ttop);

  // hit[0]=address-only, hit[1]=reserved, hit[2]=illegal
  for (genvar k = 0; k < 3; k++) begin : g_kind
    assign hit[k] = valid && (kind == tkind_e'(k + 1));
  end
endmodule

// File: rtl/bem_status.sv
module bem_status #(
  parameter int MID_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [bem_pkg::NEV-1:0]   ev,
  input  logic [bem_pkg::TYPE_W-1:0] ev_type,
  input  logic [MID_W-1:0]          ev_mid,
  input  logic                      clr_wr,
  input  logic [bem_pkg::NEV-1:0]   clr_bits,
  input  logic [bem_pkg::NEV-1:0]   irq_en,
  input  logic [bem_pkg::NEV-1:0]   mc_sel,
  output logic [bem_pkg::NEV-1:0]   status,
  output logic [bem_pkg::TYPE_W-1:0] cap_type,
  output logic [MID_W-1:0]          cap_mid,
  output logic                      irq,
  output logic                      mchk
);
  import bem_pkg::*;

  logic [NEV-1:0] kept;
  logic [1:0]     lines;

  for (genvar i = 0; i < NEV; i++) begin : g_bit
    assign kept[i] = status[i] && !(clr_wr && clr_bits[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status[i] <= 1'b0;
      else        status[i] <= kept[i] || ev[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_type <= '0;
      cap_mid  <= '0;
    end else if ((kept == '0) && (ev != '0)) begin
      cap_type <= ev_type;
      cap_mid  <= ev_mid;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_line
    assign lines[g] = line_or(status, irq_en, mc_sel, g[0]);
  end
  assign irq  = lines[0];
  assign mchk = lines[1];
endmodule

// File: rtl/bus_err_mon.sv
module bus_err_mon #(
  parameter int MID_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_start,
  input  logic             addr_end,
  input  logic             data_start,
  input  logic             data_end,
  input  logic [4:0]       ttype,
  input  logic [MID_W-1:0] mid,
  input  logic             xfer_err,
  input  logic [CNT_W-1:0] addr_limit,
  input  logic [CNT_W-1:0] data_limit,
  input  logic [5:0]       irq_en,
  input  logic [5:0]       mc_sel,
  input  logic             clr_wr,
  input  logic [5:0]       clr_bits,
  output logic [5:0]       status,
  output logic [4:0]       cap_type,
  output logic [MID_W-1:0] cap_mid,
  output logic             irq,
  output logic             mchk
);
  import bem_pkg::*;

  logic [1:0]       t_start;
  logic [1:0]       t_stop;
  logic [1:0]       t_exp;
  logic [CNT_W-1:0] t_lim [2];
  logic [2:0]       type_hit;
  logic [NEV-1:0]   ev_vec;
  logic [4:0]       own_type;
  logic [MID_W-1:0] own_mid;
  logic [4:0]       ev_type;
  logic [MID_W-1:0] ev_mid;

  assign t_start = {data_start, addr_start};
  assign t_stop  = {data_end, addr_end};
  assign t_lim[0] = addr_limit;
  assign t_lim[1] = data_limit;

  for (genvar g = 0; g < 2; g++) begin : g_tmr
    bem_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (t_start[g]),
      .stop   (t_stop[g]),
      .limit  (t_lim[g]),
      .expire (t_exp[g])
    );
  end

  bem_classify u_cls (
    .valid (addr_start),
    .ttop  (ttype[4:2]),
    .hit   (type_hit)
  );

  // Owner of the most recent address tenure
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_type <= '0;
      own_mid  <= '0;
    end else if (addr_start) begin
      own_type <= ttype;
      own_mid  <= mid;
    end
  end

  assign ev_vec[EV_ATO]   = t_exp[0];
  assign ev_vec[EV_DTO]   = t_exp[1];
  assign ev_vec[EV_AONLY] = type_hit[0];
  assign ev_vec[EV_RSVD]  = type_hit[1];
  assign ev_vec[EV_ILL]   = type_hit[2];
  assign ev_vec[EV_TEA]   = xfer_err;

  assign ev_type = (type_hit != '0) ? ttype : own_type;
  assign ev_mid  = (type_hit != '0) ? mid   : own_mid;

  bem_status #(.MID_W(MID_W)) u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev_vec),
    .ev_type  (ev_type),
    .ev_mid   (ev_mid),
    .clr_wr   (clr_wr),
    .clr_bits (clr_bits),
    .irq_en   (irq_en),
    .mc_sel   (mc_sel),
    .status   (status),
    .cap_type (cap_type),
    .cap_mid  (cap_mid),
    .irq      (irq),
    .mchk     (mchk)
  );
endmodule

// File: rtl/bus_err_mon_chk.sv
module bus_err_mon_chk #(
  parameter int MID_W = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr_start,
  input logic [4:0]       ttype,
  input logic             xfer_err,
  input logic [CNT_W-1:0] addr_limit,
  input logic [CNT_W-1:0] data_limit,
  input logic [5:0]       irq_en,
  input logic             clr_wr,
  input logic [5:0]       status,
  input logic [4:0]       cap_type,
  input logic [MID_W-1:0] cap_mid,
  input logic             irq,
  input logic             mchk,
  input logic [5:0]       ev_vec
);
  // R4
  addr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_limit == '0) |-> !ev_vec[0]);

  // R4
  data_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_limit == '0) |-> !ev_vec[1]);

  // R2
  ato_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vec[0] |=> status[0]);

  // R7
  tea_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> status[5]);

  // R6
  ill_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_start && (ttype[4:2] == 3'b111)) |=> status[4]);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((status & $past(status)) == $past(status)));

  // R10
  quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & irq_en) == '0) |-> (!irq && !mchk));

  // R9
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status != '0) && !clr_wr) |=> ($stable(cap_type) && $stable(cap_mid)));
endmodule

bind bus_err_mon bus_err_mon_chk #(.MID_W(MID_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_start (addr_start),
  .ttype      (ttype),
  .xfer_err   (xfer_err),
  .addr_limit (addr_limit),
  .data_limit (data_limit),
  .irq_en     (irq_en),
  .clr_wr     (clr_wr),
  .status     (status),
  .cap_type   (cap_type),
  .cap_mid    (cap_mid),
  .irq        (irq),
  .mchk       (mchk),
  .ev_vec     (ev_vec)
);

// File: tb/bus_err_mon_tb.sv
module bus_err_mon_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        addr_start, addr_end, data_start, data_end;
  logic [4:0]  ttype;
  logic [3:0]  mid;
  logic        xfer_err;
  logic [15:0] addr_limit, data_limit;
  logic [5:0]  irq_en, mc_sel, clr_bits;
  logic        clr_wr;
  logic [5:0]  status;
  logic [4:0]  cap_type;
  logic [3:0]  cap_mid;
  logic        irq, mchk;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  bus_err_mon u_dut (
    .clk(clk), .rst_n(rst_n), .addr_start(addr_start), .addr_end(addr_end),
    .data_start(data_start), .data_end(data_end), .ttype(ttype), .mid(mid),
    .xfer_err(xfer_err), .addr_limit(addr_limit), .data_limit(data_limit),
    .irq_en(irq_en), .mc_sel(mc_sel), .clr_wr(clr_wr), .clr_bits(clr_bits),
    .status(status), .cap_type(cap_type), .cap_mid(cap_mid),
    .irq(irq), .mchk(mchk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_wr = 1'b1; clr_bits = 6'h3F;
    tick(1);
    clr_wr = 1'b0; clr_bits = 6'h00;
  endtask

  task automatic astart(input logic [4:0] t, input logic [3:0] m);
    addr_start = 1'b1; ttype = t; mid = m;
    tick(1);
    addr_start = 1'b0;
  endtask

  task automatic aend();
    addr_end = 1'b1; tick(1); addr_end = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 0);
    chk("R1 irq", irq, 0);
    chk("R1 mchk", mchk, 0);
    chk("R1 cap_type", cap_type, 0);
    chk("R1 cap_mid", cap_mid, 0);
  endtask

  task automatic t_addr_timeout();
    addr_limit = 16'd4;
    astart(5'h02, 4'd3);
    tick(3);
    chk("R2 not yet", status[0], 0);
    tick(1);
    chk("R2 expired", status[0], 1);
    chk("R9 cap_type from owner", cap_type, 5'h02);
    chk("R9 cap_mid from owner", cap_mid, 4'd3);
    aend();
    clear_all();
    chk("R8 cleared", status, 0);
    astart(5'h02, 4'd3);
    tick(3);
    aend();
    tick(6);
    chk("R2 end on last cycle", status[0], 0);
  endtask

  task automatic t_data_timeout();
    addr_limit = 16'd0;
    data_limit = 16'd2;
    data_start = 1'b1; tick(1); data_start = 1'b0;
    aend();
    chk("R5 data not yet", status[1], 0);
    tick(1);
    chk("R3 R5 data expired despite addr end", status[1], 1);
    clear_all();
    data_start = 1'b1; tick(1); data_start = 1'b0;
    tick(1);
    data_end = 1'b1; tick(1); data_end = 1'b0;
    tick(4);
    chk("R3 data end on last cycle", status[1], 0);
  endtask

  task automatic t_zero();
    addr_limit = 16'd0;
    astart(5'h02, 4'd1);
    tick(40);
    chk("R4 zero limit", status[0], 0);
    aend();
  endtask

  task automatic t_restart();
    addr_limit = 16'd4;
    astart(5'h02, 4'd2);
    tick(1);
    astart(5'h02, 4'd2);
    tick(3);
    chk("R5 restart delays", status[0], 0);
    tick(1);
    chk("R5 restart expiry", status[0], 1);
    aend();
    addr_limit = 16'd0;
    clear_all();
  endtask

  task automatic t_types();
    addr_limit = 16'd0;
    astart(5'h05, 4'd1);
    chk("R6 data type", status, 0);
    ttype = 5'h1E; tick(2);
    chk("R6 ignored without start", status, 0);
    astart(5'h12, 4'd7);
    chk("R6 address-only", status, 6'b000100);
    chk("R9 cap_type", cap_type, 5'h12);
    chk("R9 cap_mid", cap_mid, 4'd7);
    astart(5'h19, 4'd2);
    chk("R6 reserved", status, 6'b001100);
    chk("R9 held", cap_type, 5'h12);
    clear_all();
    astart(5'h1E, 4'd9);
    chk("R6 illegal", status, 6'b010000);
    chk("R9 recapture", cap_mid, 4'd9);
    clear_all();
  endtask

  task automatic t_xfer();
    xfer_err = 1'b1; tick(1); xfer_err = 1'b0;
    chk("R7 transfer error", status, 6'b100000);
  endtask

  task automatic t_w1c();
    astart(5'h1C, 4'd4);
    clr_wr = 1'b1; clr_bits = 6'b100000; tick(1);
    clr_wr = 1'b0; clr_bits = 6'b0;
    chk("R8 partial clear", status, 6'b010000);
    xfer_err = 1'b1; tick(1); xfer_err = 1'b0;
    clr_wr = 1'b1; clr_bits = 6'b100000; xfer_err = 1'b1; tick(1);
    clr_wr = 1'b0; clr_bits = 6'b0; xfer_err = 1'b0;
    chk("R8 set beats clear", status, 6'b110000);
  endtask

  task automatic t_route();
    irq_en = 6'h3F; mc_sel = 6'b100000; tick(1);
    chk("R10 regular", irq, 1);
    chk("R10 machine check", mchk, 1);
    irq_en = 6'b100000; tick(1);
    chk("R11 masked irq", irq, 0);
    chk("R11 status kept", status[4], 1);
    chk("R10 mchk still", mchk, 1);
    mc_sel = 6'b0; tick(1);
    chk("R10 rerouted irq", irq, 1);
    chk("R10 rerouted mchk", mchk, 0);
    irq_en = 6'b0;
    clear_all();
    xfer_err = 1'b1; tick(1); xfer_err = 1'b0;
    chk("R11 masked recorded", status[5], 1);
    chk("R11 no irq", irq, 0);
    chk("R11 no mchk", mchk, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    addr_start = 0; addr_end = 0; data_start = 0; data_end = 0;
    ttype = 0; mid = 0; xfer_err = 0; addr_limit = 0; data_limit = 0;
    irq_en = 0; mc_sel = 0; clr_wr = 0; clr_bits = 0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_addr_timeout();
    t_data_timeout();
    t_zero();
    t_restart();
    t_types();
    t_xfer();
    t_w1c();
    t_route();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule